// File: doc/BRIEF.md
# SPI Serial EEPROM Device Model

A synthesizable SPI target that behaves like a small serial EEPROM. It is meant to sit as a bus-functional device inside controller testbenches or emulation builds. The block oversamples the SPI pins with a fast system clock and decodes the usual six-opcode EEPROM command set. It holds a status register with a write-enable latch, a busy flag, two block-protect bits and a protect-enable bit.

A read command is followed by an address of `ADDR_BYTES` bytes, most significant byte first. The block then streams consecutive bytes for as long as the master keeps clocking. A data write collects bytes into a page buffer whose offset wraps inside the addressed page. When chip select is released after a whole number of bytes, the page buffer is committed to the array. A busy interval of `WRITE_CYCLES` system clocks follows, modelling the internal programming time. The array size, page size, address length and write time are parameters.

Top module: `spi_eep_top`

## Requirements
- R1: After reset the status byte reads 0x00. Its layout is bit 0 busy, bit 1 write-enable latch, bits 3:2 block protect, bit 7 protect enable, and the other bits read 0. The opcodes are: 0x06 set latch, 0x04 clear latch, 0x05 read status, 0x01 write status, 0x03 read data, 0x02 write data.
- R2: After a read or write opcode the block takes ADDR_BYTES address bytes, most significant first. Address bits above the array size are ignored.
- R3: A read returns the byte at the address, then the following bytes for as long as clocking continues. The address wraps from the last array byte to 0.
- R4: A write-data or write-status command sent while the latch is clear has no effect on the array or the status.
- R5: Opcode 0x06 sets the latch and 0x04 clears it. The rising edge of chip select that ends an accepted write-data or write-status command also clears it.
- R6: Write data bytes go to consecutive offsets that wrap within the addressed page. Bytes past the page end overwrite the start of the same page.
- R7: A write whose transfer ends after a partial byte is discarded: no array change and no busy interval.
- R8: A committed write sets the busy bit at once. Busy stays set for WRITE_CYCLES system clocks and then clears.
- R9: While busy, every opcode except read status is ignored: a read returns 0x00 and a set-latch command leaves the latch clear.
- R10: Write status updates only bits 7, 3 and 2. While either protect bit is set, data writes leave the array unchanged.
- R11: SPI mode 0: MOSI is sampled on the rising SCLK edge, MISO changes after the falling edge, MSB first. MISO is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the SPI pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock from the master |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master, 0 when deselected |

## Verification
The key coincidence is at the chip-select rising edge that ends a write. In that single system clock the latch clears, the page buffer commits and the busy counter loads. The bench provokes it by issuing a status read right after every write, and expects 0x01 (busy set, latch clear) plus the protect bits. A second pairing is a busy interval overlapping a new opcode. The bench sends a read or a set-latch command inside that window and judges it by a 0x00 read stream and by a clear latch once the write time has passed.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_READ, ST_WDATA, ST_SDATA, ST_STAT, ST_SKIP
  } cmd_st_e;
endpackage

// File: rtl/spi_eep_link.sv
module spi_eep_link (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       miso_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       cs_rise_o,
  output logic       aligned_o
);
  logic [2:0] sclk_sy, cs_sy;
  logic [1:0] mosi_sy;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;
  logic       load_pend;
  logic       cs_s, s_rise, s_fall;

  assign cs_s      = cs_sy[1];
  assign s_rise    = sclk_sy[1] & ~sclk_sy[2];
  assign s_fall    = ~sclk_sy[1] & sclk_sy[2];
  assign cs_rise_o = cs_sy[1] & ~cs_sy[2];
  assign aligned_o = (bit_cnt == 3'd0);
  assign miso_o    = ~cs_s & tx_sr[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
    end else begin
      sclk_sy <= {sclk_sy[1:0], sclk_i};
      cs_sy   <= {cs_sy[1:0], cs_ni};
      mosi_sy <= {mosi_sy[0], mosi_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt     <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      load_pend   <= 1'b0;
      byte_done_o <= 1'b0;
      rx_byte_o   <= '0;
    end else begin
      byte_done_o <= 1'b0;
      if (cs_s) begin
        bit_cnt   <= '0;
        tx_sr     <= '0;
        load_pend <= 1'b0;
      end else begin
        if (s_rise) begin
          rx_sr   <= {rx_sr[5:0], mosi_sy[1]};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            load_pend   <= 1'b1;
            byte_done_o <= 1'b1;
            rx_byte_o   <= {rx_sr, mosi_sy[1]};
          end
        end
        if (s_fall) begin
          if (load_pend) begin
            tx_sr     <= tx_byte_i;
            load_pend <= 1'b0;
          end else begin
            tx_sr <= {tx_sr[6:0], 1'b0};
          end
        end
      end
    end
  end

  // a completed byte always leaves the bit counter on a byte boundary
  assert_byte_aligned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> aligned_o);
endmodule

// File: rtl/spi_eep_store.sv
module spi_eep_store #(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 200
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic [$clog2(MEM_BYTES)-1:0]               rd_addr_i,
  output logic [7:0]                                 rd_data_o,
  input  logic                                       pb_clr_i,
  input  logic                                       pb_we_i,
  input  logic [$clog2(PAGE_BYTES)-1:0]              pb_off_i,
  input  logic [7:0]                                 pb_data_i,
  input  logic                                       commit_i,
  input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] page_i,
  input  logic                                       start_i,
  output logic                                       busy_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [7:0]            mem   [MEM_BYTES];
  logic [7:0]            pbuf  [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [CW-1:0]         cnt;

  assign rd_data_o = mem[rd_addr_i];
  assign busy_o    = (cnt != '0);

  always_ff @(posedge clk_i) begin
    if (pb_we_i) pbuf[pb_off_i] <= pb_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pmask <= '0;
    else if (pb_clr_i) pmask <= '0;
    else if (pb_we_i) pmask[pb_off_i] <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pmask[i]) mem[{page_i, PW'(i)}] <= pbuf[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else if (start_i) cnt <= CW'(WRITE_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assert_commit_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !busy_o);
  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  assert_addr_fit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (AW > PW));
endmodule

// File: rtl/spi_eep_ctrl.sv
module spi_eep_ctrl
  import spi_eep_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16,
  parameter int ADDR_BYTES = 2
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       byte_done_i,
  input  logic [7:0]                                 rx_byte_i,
  input  logic                                       cs_rise_i,
  input  logic                                       aligned_i,
  input  logic                                       busy_i,
  input  logic [7:0]                                 rd_data_i,
  output logic [$clog2(MEM_BYTES)-1:0]               rd_addr_o,
  output logic [7:0]                                 tx_byte_o,
  output logic                                       pb_clr_o,
  output logic                                       pb_we_o,
  output logic [$clog2(PAGE_BYTES)-1:0]              pb_off_o,
  output logic [7:0]                                 pb_data_o,
  output logic                                       commit_o,
  output logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] page_o,
  output logic                                       start_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  cmd_st_e       st_q;
  logic [1:0]    acnt_q;
  logic [AW-1:0] acc_q, acc_nxt, addr_q;
  logic [PW-1:0] off_nxt;
  logic          wel_q, wpen_q, rd_q, got_q, wcmd_q, sdat_q;
  logic [1:0]    bp_q;
  logic [2:0]    sr_pend_q;
  logic          data_ok, stat_ok;
  logic [7:0]    status;

  assign acc_nxt   = (acc_q << 8) | AW'(rx_byte_i);
  assign off_nxt   = addr_q[PW-1:0] + 1'b1;
  assign rd_addr_o = addr_q;
  assign pb_off_o  = addr_q[PW-1:0];
  assign page_o    = addr_q[AW-1:PW];
  assign pb_data_o = rx_byte_i;
  assign pb_we_o   = byte_done_i && (st_q == ST_WDATA);
  assign pb_clr_o  = byte_done_i && (st_q == ST_OPC) && (rx_byte_i == OP_WRITE)
                     && wel_q && !busy_i;
  assign status    = {wpen_q, 3'b000, bp_q, wel_q, busy_i};

  assign data_ok  = cs_rise_i && wcmd_q && got_q && aligned_i;
  assign commit_o = data_ok && !sdat_q && (bp_q == 2'b00);
  assign stat_ok  = data_ok && sdat_q;
  assign start_o  = commit_o || stat_ok;

  always_comb begin
    unique case (st_q)
      ST_READ: tx_byte_o = rd_data_i;
      ST_STAT: tx_byte_o = status;
      default: tx_byte_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OPC; acnt_q <= '0; acc_q <= '0; addr_q <= '0;
      wel_q <= 1'b0; wpen_q <= 1'b0; bp_q <= '0; sr_pend_q <= '0;
      rd_q <= 1'b0; got_q <= 1'b0; wcmd_q <= 1'b0; sdat_q <= 1'b0;
    end else begin
      if (byte_done_i) begin
        unique case (st_q)
          ST_OPC: begin
            acnt_q <= '0;
            if (busy_i && rx_byte_i != OP_RDSR) st_q <= ST_SKIP;
            else begin
              unique case (rx_byte_i)
                OP_WREN:  begin wel_q <= 1'b1; st_q <= ST_SKIP; end
                OP_WRDI:  begin wel_q <= 1'b0; st_q <= ST_SKIP; end
                OP_RDSR:  st_q <= ST_STAT;
                OP_WRSR:  begin
                  st_q   <= wel_q ? ST_SDATA : ST_SKIP;
                  wcmd_q <= wel_q;
                  sdat_q <= 1'b1;
                end
                OP_READ:  begin st_q <= ST_ADDR; rd_q <= 1'b1; end
                OP_WRITE: begin
                  st_q   <= wel_q ? ST_ADDR : ST_SKIP;
                  wcmd_q <= wel_q;
                  sdat_q <= 1'b0;
                  rd_q   <= 1'b0;
                end
                default:  st_q <= ST_SKIP;
              endcase
            end
          end
          ST_ADDR: begin
            acc_q <= acc_nxt;
            if (acnt_q == 2'(ADDR_BYTES - 1)) begin
              addr_q <= acc_nxt;
              st_q   <= rd_q ? ST_READ : ST_WDATA;
            end else begin
              acnt_q <= acnt_q + 2'd1;
            end
          end
          ST_READ:  addr_q <= addr_q + 1'b1;
          ST_WDATA: begin
            addr_q <= {addr_q[AW-1:PW], off_nxt};
            got_q  <= 1'b1;
          end
          ST_SDATA: begin
            sr_pend_q <= {rx_byte_i[7], rx_byte_i[3:2]};
            got_q     <= 1'b1;
            st_q      <= ST_SKIP;
          end
          default: ;
        endcase
      end
      if (cs_rise_i) begin
        st_q   <= ST_OPC;
        wcmd_q <= 1'b0;
        got_q  <= 1'b0;
        if (wcmd_q) wel_q <= 1'b0;
        if (stat_ok) {wpen_q, bp_q} <= sr_pend_q;
      end
    end
  end

  assert_wel_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(byte_done_i && rx_byte_i == OP_WREN));
  assert_busy_no_wel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> !$rose(wel_q));
  assert_commit_wel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> wel_q);
  assert_wel_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !wel_q);
endmodule

// File: rtl/spi_eep_top.sv
module spi_eep_top #(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 16,
  parameter int ADDR_BYTES   = 2,
  parameter int WRITE_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic          byte_done, cs_rise, aligned, busy;
  logic [7:0]    rx_byte, tx_byte, rd_data, pb_data;
  logic [AW-1:0] rd_addr;
  logic          pb_clr, pb_we, commit, start;
  logic [PW-1:0] pb_off;
  logic [AW-PW-1:0] page;

  spi_eep_link u_link (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .tx_byte_i(tx_byte), .miso_o,
    .byte_done_o(byte_done), .rx_byte_o(rx_byte),
    .cs_rise_o(cs_rise), .aligned_o(aligned)
  );

  spi_eep_ctrl #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .ADDR_BYTES(ADDR_BYTES)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .byte_done_i(byte_done), .rx_byte_i(rx_byte), .cs_rise_i(cs_rise),
    .aligned_i(aligned), .busy_i(busy), .rd_data_i(rd_data),
    .rd_addr_o(rd_addr), .tx_byte_o(tx_byte), .pb_clr_o(pb_clr),
    .pb_we_o(pb_we), .pb_off_o(pb_off), .pb_data_o(pb_data),
    .commit_o(commit), .page_o(page), .start_o(start)
  );

  spi_eep_store #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_store (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pb_clr_i(pb_clr), .pb_we_i(pb_we), .pb_off_i(pb_off), .pb_data_i(pb_data),
    .commit_i(commit), .page_i(page), .start_i(start), .busy_o(busy)
  );
endmodule

// File: tb/spi_eep_top_tb.sv
`timescale 1ns/1ps
module spi_eep_top_tb;
  localparam int MEM = 256, PAGE = 16, WCYC = 200, HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int   n_chk = 0, n_fail = 0;
  logic [7:0] exp_mem [MEM];
  logic [7:0] exp_sr = 8'h00;
  logic [7:0] wbuf [32];

  always #2.5 clk = ~clk;

  spi_eep_top #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .ADDR_BYTES(2), .WRITE_CYCLES(WCYC))
    u_dut (.clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n); repeat (n) @(negedge clk); endtask
  task automatic sel();   cs_n = 1'b0; wait_clk(HALF); endtask
  task automatic desel(); wait_clk(HALF); cs_n = 1'b1; wait_clk(10); endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      wait_clk(HALF);
      rx[b] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic put(input logic [7:0] tx);
    logic [7:0] d;
    xfer(tx, d);
  endtask

  task automatic cmd1(input logic [7:0] op); sel(); put(op); desel(); endtask

  task automatic rdsr(output logic [7:0] s);
    sel(); put(8'h05); xfer(8'h00, s); desel();
  endtask

  task automatic do_write(input logic [15:0] a, input int len, input bit model);
    logic [3:0] off;
    sel(); put(8'h02); put(a[15:8]); put(a[7:0]);
    for (int i = 0; i < len; i++) put(wbuf[i]);
    desel();
    if (model && exp_sr[3:2] == 2'b00) begin
      off = a[3:0];
      for (int i = 0; i < len; i++) begin
        exp_mem[{a[7:4], off}] = wbuf[i];
        off++;
      end
    end
  endtask

  task automatic do_read(input string req, input logic [15:0] a, input int len);
    logic [7:0] d;
    sel(); put(8'h03); put(a[15:8]); put(a[7:0]);
    for (int i = 0; i < len; i++) begin
      xfer(8'h00, d);
      chk(req, d, exp_mem[8'(a[7:0] + i)]);
    end
    desel();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    wait_clk(WCYC + 20);
    rdsr(s);
    chk("R8 busy cleared", s, exp_sr);
  endtask

  initial begin
    wait_clk(190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    void'($urandom(32'h5EED));
    for (int i = 0; i < MEM; i++) exp_mem[i] = 8'hFF;
    wait_clk(4); rst_n = 1'b1; wait_clk(4);

    // R1 reset state, R11 idle MISO with SCLK toggling and CS high
    rdsr(s); chk("R1 reset status", s, 8'h00);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b1; wait_clk(HALF); chk("R11 miso idle", miso, 1'b0);
      sclk = 1'b0; wait_clk(HALF); chk("R11 miso idle", miso, 1'b0);
    end

    // R5 latch set/clear
    cmd1(8'h06); rdsr(s); chk("R5 latch set", s, 8'h02);
    cmd1(8'h04); rdsr(s); chk("R5 latch clear", s, 8'h00);

    // R4 write without latch
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h11 * (i + 1);
    do_write(16'h0010, 4, 1'b0);
    rdsr(s); chk("R4 no busy without latch", s, 8'h00);
    do_read("R4 array untouched", 16'h0010, 4);

    // R8 busy right after commit, latch cleared on the same edge
    cmd1(8'h06);
    do_write(16'h0010, 4, 1'b1);
    rdsr(s); chk("R8 R5 busy and latch cleared", s, 8'h01);
    wait_ready();
    do_read("R2 R3 readback", 16'h0010, 4);

    // R9 read during busy returns zero
    for (int i = 0; i < 2; i++) wbuf[i] = 8'hA5 + i;
    cmd1(8'h06); do_write(16'h0030, 2, 1'b1);
    sel(); put(8'h03); put(8'h00); put(8'h30); xfer(8'h00, d); desel();
    chk("R9 read ignored while busy", d, 8'h00);
    wait_ready();

    // R9 set-latch during busy ignored
    cmd1(8'h06); do_write(16'h0034, 2, 1'b1);
    cmd1(8'h06);
    wait_ready();
    rdsr(s); chk("R9 latch stays clear", s, 8'h00);

    // R6 page wrap: 20 bytes starting at offset 12 of page 0x20
    for (int i = 0; i < 20; i++) wbuf[i] = 8'h40 + i;
    cmd1(8'h06); do_write(16'h002C, 20, 1'b1);
    wait_ready();
    do_read("R6 page wrap", 16'h0020, 16);
    do_read("R6 next page intact", 16'h0030, 4);

    // R3 read wraps at array end
    for (int i = 0; i < 2; i++) wbuf[i] = 8'hC0 + i;
    cmd1(8'h06); do_write(16'h00FE, 2, 1'b1); wait_ready();
    do_read("R3 address wrap", 16'h00FE, 4);

    // R2 upper address bits ignored, second byte is the low byte
    wbuf[0] = 8'h5A;
    cmd1(8'h06); do_write(16'h0150, 1, 1'b1); wait_ready();
    do_read("R2 MSB first", 16'h0050, 1);

    // R7 partial byte discards
    cmd1(8'h06);
    sel(); put(8'h02); put(8'h00); put(8'h60); put(8'hAA);
    for (int b = 0; b < 3; b++) begin
      mosi = 1'b1; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    desel();
    rdsr(s); chk("R7 no busy, latch cleared", s, 8'h00);
    do_read("R7 array untouched", 16'h0060, 1);

    // R10 status write masks, protect lock
    cmd1(8'h06); sel(); put(8'h01); put(8'hFF); desel();
    exp_sr = 8'h8C; wait_ready();
    rdsr(s); chk("R10 writable bits only", s, 8'h8C);
    wbuf[0] = 8'h77;
    cmd1(8'h06); do_write(16'h0070, 1, 1'b1);
    rdsr(s); chk("R10 locked write not started", s, 8'h8C);
    do_read("R10 locked array", 16'h0070, 1);
    cmd1(8'h06); sel(); put(8'h01); put(8'h00); desel();
    exp_sr = 8'h00; wait_ready();
    sel(); put(8'h01); put(8'h8C); desel();
    rdsr(s); chk("R4 status write without latch", s, 8'h00);

    // random writes and readbacks
    for (int it = 0; it < 12; it++) begin
      logic [15:0] a;
      int len;
      a   = 16'($urandom % MEM);
      len = 1 + ($urandom % 20);
      for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
      cmd1(8'h06); do_write(a, len, 1'b1);
      wait_ready();
      do_read("R3 R6 random", {8'h00, a[7:4], 4'h0}, 18);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule